// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Engine

This block sits on the host side of a single serial port to a sigma-delta converter. A requester hands it one operation at a time: a register access, a reset burst for the serial port, entry into streaming of conversion results, or exit from streaming. For a register access the block forms the 8-bit command byte and shifts the payload at the width fixed for that address. It then returns the read value, or simply acknowledges a write. The port is a four-wire master in clock-polarity-high, second-edge mode with the most significant bit first.

The device's data-out pin also serves as its conversion-ready flag. Before a data register read, the engine therefore lowers chip select and watches that pin for a high-to-low transition. It only starts clocking after that transition, and it gives up after a programmable number of cycles. In streaming mode the engine keeps chip select low and sends no command bytes. On every ready fall it pulls in one result and presents it on a separate strobe. The engine keeps its own copy of the status-append bit of the mode register, because that bit decides whether a data read is 24 or 32 bits long.

Top module: `sdadc_port_engine`

## Requirements
- R1: Every register access is one chip-select frame. The frame opens with a command byte of the form {bit7 = 0, bit6 = 1 for read / 0 for write, bits5:3 = address, bit2 = streaming request, bits1:0 = 0}, followed by the payload. Bits are sent most significant first. The serial clock idles high and holds each level for ClkHalf system cycles. Data changes on the falling edge and MISO is sampled on the rising edge.
- R2: The payload width follows the address: 8 bits for addresses 0, 4 and 5; 24 bits for addresses 1, 2, 6 and 7; for address 3, 24 bits, or 32 bits when the append flag is set.
- R3: A write sends the low payload-width bits of reqWdata after the command byte, then acknowledges with rdData = 0 and rdErr = 0.
- R4: A read sends zeros after the command byte. It returns the bits received during the payload, zero-extended, on rdData together with reqAck.
- R5: A read of address 3 lowers chip select and produces no clock edge until a falling edge is seen on MISO. It then sends command byte 0x58 and reads the result.
- R6: If no MISO fall arrives within timeoutLimit cycles, the read ends with reqAck, rdErr = 1 and rdData = 0. Chip select is released and no clock edge occurs.
- R7: A write to address 1 copies reqWdata bit 20 into the append flag. While the flag is set, data reads and streamed results are 32 bits (the status byte is the low 8 bits).
- R8: reqOp = 1 sends 48 consecutive ones in one frame and clears the append flag. reqReady then stays low for exactly HoldoffCycles cycles after chip select rises, and reqAck arrives at the end of that wait.
- R9: reqOp = 2 sends the single byte 0x5C and acknowledges. Chip select then stays low. On every later MISO fall, the engine shifts 24 or 32 bits with MOSI low and pulses streamValid with the result on rdData.
- R10: reqOp = 3 while streaming raises chip select, acknowledges with rdErr = 0, and ends streaming.
- R11: Any other request while streaming is acknowledged with rdErr = 1 and causes no bus activity.
- R12: reqOp = 3 outside streaming is acknowledged with rdErr = 0 and causes no bus activity.
- R13: Out of reset, chip select is high, the clock is high and reqReady is high. The clock is high whenever chip select is high, and reqAck and streamValid never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqOp | input | 2 | 0 access, 1 reset burst, 2 enter streaming, 3 leave streaming |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | 3 | Register address |
| reqWdata | input | 32 | Write payload, right aligned |
| timeoutLimit | input | TimeW | Cycles allowed for the ready fall |
| reqReady | output | 1 | Engine accepts a request |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read value or streamed result |
| rdErr | output | 1 | Error qualifier, valid with reqAck |
| streamValid | output | 1 | One-cycle pulse for each streamed result |
| spiSclk | output | 1 | Serial clock, idle high |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to device |
| spiMiso | input | 1 | Serial data and ready flag from device |

## Verification
A register access completes about 2·ClkHalf·(8 + width) cycles after it is accepted, plus a few cycles for the MISO synchronizer and the acknowledge register. A data read adds the time until the bench drops the ready level, and a reset adds exactly HoldoffCycles. The scoreboard does not wait a fixed number of cycles. It queues the expected frame, bit count, read value and error flag before each request, and it pops an item only on the reqAck or streamValid pulse. The bit count and frame content are taken from a device model that counts rising clock edges. The holdoff is the one result whose latency is checked to the exact cycle: the bench counts cycles from the rise of chip select to reqAck and checks that reqReady stays low throughout. The bench also checks that no clock edge occurs while the engine waits for ready.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  localparam int FrameW = 48;   // widest frame: reset burst
  localparam int CmdW   = 8;
  localparam int ResetBits = 48;
  localparam logic [2:0] ModeAddr = 3'd1;
  localparam logic [2:0] DataAddr = 3'd3;
  localparam int AppendBit = 20;

  typedef enum logic [1:0] {
    OP_ACCESS = 2'd0,
    OP_RESET  = 2'd1,
    OP_STREAM = 2'd2,
    OP_LEAVE  = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [FrameW-1:0] word;   // left aligned, MSB leaves first
    logic [5:0]        nBits;
  } shiftCmd_t;

  function automatic logic [5:0] regWidth(input logic [2:0] addr, input logic append);
    case (addr)
      3'd0, 3'd4, 3'd5: regWidth = 6'd8;
      3'd3:             regWidth = append ? 6'd32 : 6'd24;
      default:          regWidth = 6'd24;
    endcase
  endfunction

  function automatic logic [31:0] widthMask(input logic [5:0] w);
    for (int i = 0; i < 32; i++) widthMask[i] = (i < int'(w));
  endfunction

  function automatic logic [7:0] mkCmd(input logic rd, input logic [2:0] addr, input logic cont);
    mkCmd = {1'b0, rd, addr, cont, 2'b00};
  endfunction

  function automatic logic [FrameW-1:0] packFrame(input logic [7:0] cmdByte,
                                                  input logic [31:0] payload,
                                                  input logic [5:0] w);
    logic [FrameW-1:0] body;
    body = {16'b0, payload & widthMask(w)};
    packFrame = {cmdByte, 40'b0} | (body << (6'd40 - w));
  endfunction

endpackage

// File: rtl/sdadc_dpath.sv
module sdadc_dpath
  import sdadc_pkg::*;
#(
  parameter int ClkHalf = 4   // system cycles per clock level, at least 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  shiftCmd_t  cmd,
  input  logic       misoIn,
  output logic       sclk,
  output logic       mosi,
  output logic       shiftBusy,
  output logic       shiftDone,
  output logic [31:0] rxWord,
  output logic       misoFall
);

  localparam int DivW = (ClkHalf > 1) ? $clog2(ClkHalf) : 1;

  logic [DivW-1:0]   divCnt;
  logic [FrameW-1:0] shReg;
  logic [5:0]        bitsLeft;
  logic [31:0]       rxReg;
  logic              sclkR, mosiR, active, doneR;
  logic              sync1, misoSync, misoPrev;

  // two-flop synchronizer and fall detector on the data/ready pin
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1    <= 1'b1;
      misoSync <= 1'b1;
      misoPrev <= 1'b1;
    end else begin
      sync1    <= misoIn;
      misoSync <= sync1;
      misoPrev <= misoSync;
    end
  end
  assign misoFall = misoPrev & ~misoSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      shReg    <= '0;
      bitsLeft <= '0;
      rxReg    <= '0;
      sclkR    <= 1'b1;
      mosiR    <= 1'b1;
      active   <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (cmd.load) begin
        shReg    <= cmd.word;
        bitsLeft <= cmd.nBits;
        rxReg    <= '0;
        divCnt   <= '0;
        active   <= 1'b1;
      end else if (active) begin
        if (divCnt == DivW'(ClkHalf - 1)) begin
          divCnt <= '0;
          if (sclkR) begin
            sclkR <= 1'b0;
            mosiR <= shReg[FrameW-1];
            shReg <= {shReg[FrameW-2:0], 1'b0};
          end else begin
            sclkR    <= 1'b1;
            rxReg    <= {rxReg[30:0], misoSync};
            bitsLeft <= bitsLeft - 6'd1;
            if (bitsLeft == 6'd1) begin
              active <= 1'b0;
              doneR  <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + DivW'(1);
        end
      end
    end
  end

  assign sclk      = sclkR;
  assign mosi      = mosiR;
  assign shiftBusy = active;
  assign shiftDone = doneR;
  assign rxWord    = rxReg;

  // R1: each clock level lasts more than one system cycle
  assert_sclk_level_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkR) |=> $stable(sclkR));

  // R13: clock rests high between frames
  assert_sclk_rest_high_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !cmd.load) |=> (sclkR || active));

endmodule

// File: rtl/sdadc_ctrl.sv
module sdadc_ctrl
  import sdadc_pkg::*;
#(
  parameter int TimeW         = 16,
  parameter int HoldoffCycles = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             reqWrite,
  input  logic [2:0]       reqAddr,
  input  logic [31:0]      reqWdata,
  input  logic [TimeW-1:0] timeoutLimit,
  input  logic             shiftDone,
  input  logic [31:0]      rxWord,
  input  logic             misoFall,
  output shiftCmd_t        cmd,
  output logic             csN,
  output logic             reqReady,
  output logic             reqAck,
  output logic [31:0]      rdData,
  output logic             rdErr,
  output logic             streamValid
);

  localparam int HoldW = $clog2(HoldoffCycles + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAITRDY, S_XFER, S_HOLD, S_CWAIT, S_CXFER} state_e;
  typedef enum logic [1:0] {K_REG, K_RESET, K_ENTER} kind_e;

  state_e           state;
  kind_e            kind;
  logic [2:0]       addrQ;
  logic             writeQ, appendQ;
  logic [31:0]      wdataQ;
  logic [TimeW-1:0] waitCnt;
  logic [HoldW-1:0] holdCnt;
  logic [5:0]       curW, newW, streamW;
  op_e              opIn;

  assign opIn     = op_e'(reqOp);
  assign curW     = regWidth(addrQ, appendQ);
  assign newW     = regWidth(reqAddr, appendQ);
  assign streamW  = appendQ ? 6'd32 : 6'd24;
  assign reqReady = (state == S_IDLE) || (state == S_CWAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      kind        <= K_REG;
      addrQ       <= '0;
      writeQ      <= 1'b0;
      wdataQ      <= '0;
      appendQ     <= 1'b0;
      waitCnt     <= '0;
      holdCnt     <= '0;
      cmd         <= '0;
      csN         <= 1'b1;
      reqAck      <= 1'b0;
      rdData      <= '0;
      rdErr       <= 1'b0;
      streamValid <= 1'b0;
    end else begin
      cmd.load    <= 1'b0;
      reqAck      <= 1'b0;
      rdErr       <= 1'b0;
      streamValid <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          case (opIn)
            OP_ACCESS: begin
              addrQ  <= reqAddr;
              writeQ <= reqWrite;
              wdataQ <= reqWdata;
              csN    <= 1'b0;
              kind   <= K_REG;
              if (!reqWrite && reqAddr == DataAddr) begin
                waitCnt <= '0;
                state   <= S_WAITRDY;
              end else begin
                cmd.load  <= 1'b1;
                cmd.word  <= packFrame(mkCmd(!reqWrite, reqAddr, 1'b0),
                                       reqWrite ? reqWdata : 32'd0, newW);
                cmd.nBits <= 6'(CmdW) + newW;
                state     <= S_XFER;
              end
            end
            OP_RESET: begin
              csN       <= 1'b0;
              kind      <= K_RESET;
              cmd.load  <= 1'b1;
              cmd.word  <= '1;
              cmd.nBits <= 6'(ResetBits);
              state     <= S_XFER;
            end
            OP_STREAM: begin
              csN       <= 1'b0;
              kind      <= K_ENTER;
              cmd.load  <= 1'b1;
              cmd.word  <= {mkCmd(1'b1, DataAddr, 1'b1), 40'b0};
              cmd.nBits <= 6'(CmdW);
              state     <= S_XFER;
            end
            default: begin       // leave request with nothing to leave
              reqAck <= 1'b1;
              rdData <= '0;
            end
          endcase
        end
        S_WAITRDY: begin
          if (misoFall) begin
            cmd.load  <= 1'b1;
            cmd.word  <= packFrame(mkCmd(1'b1, DataAddr, 1'b0), 32'd0, curW);
            cmd.nBits <= 6'(CmdW) + curW;
            state     <= S_XFER;
          end else begin
            waitCnt <= waitCnt + TimeW'(1);
            if (waitCnt + TimeW'(1) == timeoutLimit) begin
              csN    <= 1'b1;
              reqAck <= 1'b1;
              rdErr  <= 1'b1;
              rdData <= '0;
              state  <= S_IDLE;
            end
          end
        end
        S_XFER: if (shiftDone) begin
          case (kind)
            K_RESET: begin
              csN     <= 1'b1;
              appendQ <= 1'b0;
              holdCnt <= '0;
              state   <= S_HOLD;
            end
            K_ENTER: begin
              reqAck <= 1'b1;
              rdData <= '0;
              state  <= S_CWAIT;
            end
            default: begin
              csN    <= 1'b1;
              reqAck <= 1'b1;
              rdData <= writeQ ? 32'd0 : (rxWord & widthMask(curW));
              if (writeQ && addrQ == ModeAddr) appendQ <= wdataQ[AppendBit];
              state  <= S_IDLE;
            end
          endcase
        end
        S_HOLD: begin
          holdCnt <= holdCnt + HoldW'(1);
          if (holdCnt == HoldW'(HoldoffCycles - 1)) begin
            reqAck <= 1'b1;
            rdData <= '0;
            state  <= S_IDLE;
          end
        end
        S_CWAIT: begin
          if (reqValid) begin
            reqAck <= 1'b1;
            rdData <= '0;
            if (opIn == OP_LEAVE) begin
              csN   <= 1'b1;
              state <= S_IDLE;
            end else begin
              rdErr <= 1'b1;
            end
          end else if (misoFall) begin
            cmd.load  <= 1'b1;
            cmd.word  <= '0;
            cmd.nBits <= streamW;
            state     <= S_CXFER;
          end
        end
        S_CXFER: if (shiftDone) begin
          streamValid <= 1'b1;
          rdData      <= rxWord & widthMask(streamW);
          state       <= S_CWAIT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: an error is only ever reported together with an acknowledge
  assert_err_needs_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> reqAck);

  // R13: completion and stream strobes are exclusive
  assert_ack_stream_excl_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(reqAck && streamValid));

  // R9: streamed results arrive while the device stays selected
  assert_stream_selected_R9: assert property (@(posedge clk) disable iff (!rstN)
    streamValid |-> !csN);

endmodule

// File: rtl/sdadc_port_engine.sv
module sdadc_port_engine
  import sdadc_pkg::*;
#(
  parameter int ClkHalf       = 4,
  parameter int TimeW         = 16,
  parameter int HoldoffCycles = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             reqWrite,
  input  logic [2:0]       reqAddr,
  input  logic [31:0]      reqWdata,
  input  logic [TimeW-1:0] timeoutLimit,
  output logic             reqReady,
  output logic             reqAck,
  output logic [31:0]      rdData,
  output logic             rdErr,
  output logic             streamValid,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso
);

  shiftCmd_t   shCmd;
  logic        shiftDone, shiftBusy, misoFall;
  logic [31:0] rxWord;

  sdadc_ctrl #(.TimeW(TimeW), .HoldoffCycles(HoldoffCycles)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .timeoutLimit(timeoutLimit),
    .shiftDone(shiftDone), .rxWord(rxWord), .misoFall(misoFall),
    .cmd(shCmd), .csN(spiCsN), .reqReady(reqReady), .reqAck(reqAck),
    .rdData(rdData), .rdErr(rdErr), .streamValid(streamValid)
  );

  sdadc_dpath #(.ClkHalf(ClkHalf)) uDpath (
    .clk(clk), .rstN(rstN), .cmd(shCmd), .misoIn(spiMiso),
    .sclk(spiSclk), .mosi(spiMosi), .shiftBusy(shiftBusy),
    .shiftDone(shiftDone), .rxWord(rxWord), .misoFall(misoFall)
  );

  // R13: with the device deselected the clock sits high
  assert_idle_clock_high_R13: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> spiSclk);

  // R1: bits are only shifted inside a selected frame
  assert_shift_inside_frame_R1: assert property (@(posedge clk) disable iff (!rstN)
    shiftBusy |-> !spiCsN);

endmodule

// File: tb/sim_sdadc_port_engine.sv
module sim_sdadc_port_engine;

  localparam int ClkHalf = 4;
  localparam int Hold    = 300;

  logic        clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  logic        rstN;
  logic        reqValid, reqWrite;
  logic [1:0]  reqOp;
  logic [2:0]  reqAddr;
  logic [31:0] reqWdata;
  logic [15:0] timeoutLimit;
  logic        reqReady, reqAck, rdErr, streamValid;
  logic [31:0] rdData;
  logic        spiSclk, spiCsN, spiMosi, spiMiso;

  sdadc_port_engine #(.ClkHalf(ClkHalf), .TimeW(16), .HoldoffCycles(Hold)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .timeoutLimit(timeoutLimit), .reqReady(reqReady), .reqAck(reqAck),
    .rdData(rdData), .rdErr(rdErr), .streamValid(streamValid),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // ---------------- device model ----------------
  int          posCnt = 0;
  int          negCnt = 0;
  int          negStart = 0;
  logic [63:0] mosiHist = '0;
  logic [63:0] reply = '0;
  logic        readyLvl = 1'b1;
  logic        misoBit = 1'b1;

  always @(posedge spiSclk) if (spiCsN === 1'b0) begin
    mosiHist <= {mosiHist[62:0], spiMosi};
    posCnt   <= posCnt + 1;
  end

  always @(negedge spiSclk) if (spiCsN === 1'b0) begin
    misoBit <= reply[63 - (negCnt - negStart)];
    negCnt  <= negCnt + 1;
  end

  assign spiMiso = spiCsN ? 1'b1 : ((negCnt != negStart) ? misoBit : readyLvl);

  // ---------------- scoreboard ----------------
  typedef struct {
    int          nBits;
    logic [63:0] mosiExp;
    logic [31:0] rdExp;
    logic        errExp;
    logic        stream;
    string       tag;
    int          posStart;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miss = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectItem(input string tag, input int nBits, input logic [63:0] mosiExp,
                            input logic [31:0] rdExp, input logic errExp, input logic stream);
    item_t it;
    it.nBits = nBits; it.mosiExp = mosiExp; it.rdExp = rdExp;
    it.errExp = errExp; it.stream = stream; it.tag = tag; it.posStart = posCnt;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rstN && (reqAck || streamValid)) begin
      if (q.size() == 0) begin
        chk("unexpected completion", 64'(reqAck), 64'd0);
      end else begin
        item_t it;
        logic [63:0] mask;
        it = q.pop_front();
        mask = (it.nBits >= 64) ? '1 : ((64'd1 << it.nBits) - 64'd1);
        chk({it.tag, " strobe kind"}, 64'(streamValid), 64'(it.stream));
        chk({it.tag, " bit count"}, 64'(posCnt - it.posStart), 64'(it.nBits));
        if (it.nBits > 0) chk({it.tag, " mosi frame"}, mosiHist & mask, it.mosiExp);
        chk({it.tag, " rdData"}, 64'(rdData), 64'(it.rdExp));
        chk({it.tag, " rdErr"}, 64'(rdErr), 64'(it.errExp));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [1:0] op, input logic wr, input logic [2:0] a,
                       input logic [31:0] d);
    do @(negedge clk); while (!reqReady);
    reqOp = op; reqWrite = wr; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic arm(input logic [63:0] r);
    negStart = negCnt;
    reply    = r;
    readyLvl = 1'b1;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miss++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    int p0, cnt;
    logic readyBad;
    rstN = 1'b0; reqValid = 1'b0; reqOp = 2'd0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; timeoutLimit = 16'd400;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 reset csN", 64'(spiCsN), 64'd1);
    chk("R13 reset sclk", 64'(spiSclk), 64'd1);
    chk("R13 reset ready", 64'(reqReady), 64'd1);
    chk("R13 reset ack", 64'(reqAck), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R3 R2: write configuration register (24 bits)
    arm('0);
    expectItem("R3 write cfg", 32, 64'({8'h10, 24'hABCDEF}), 32'd0, 1'b0, 1'b0);
    issue(2'd0, 1'b1, 3'd2, 32'hFFABCDEF);
    drain();

    // R4 R2: ID register, 8 bits
    arm({8'h00, 8'hA5, 48'h0});
    expectItem("R4 read id", 16, 64'({8'h60, 8'h00}), 32'h000000A5, 1'b0, 1'b0);
    issue(2'd0, 1'b0, 3'd4, 32'd0);
    drain();

    // R4 R2: offset register, 24 bits
    arm({8'h00, 24'h123456, 32'h0});
    expectItem("R4 read offset", 32, 64'({8'h70, 24'h0}), 32'h00123456, 1'b0, 1'b0);
    issue(2'd0, 1'b0, 3'd6, 32'd0);
    drain();

    // R2: status register, 8 bits
    arm({8'h00, 8'h8A, 48'h0});
    expectItem("R2 read status", 16, 64'({8'h40, 8'h00}), 32'h0000008A, 1'b0, 1'b0);
    issue(2'd0, 1'b0, 3'd0, 32'd0);
    drain();

    // R5: data read waits for the ready fall
    arm({8'h00, 24'hC0FFEE, 32'h0});
    expectItem("R5 data read", 32, 64'({8'h58, 24'h0}), 32'h00C0FFEE, 1'b0, 1'b0);
    p0 = posCnt;
    issue(2'd0, 1'b0, 3'd3, 32'd0);
    repeat (20) @(negedge clk);
    chk("R5 no clock before ready", 64'(posCnt - p0), 64'd0);
    chk("R5 cs low while waiting", 64'(spiCsN), 64'd0);
    readyLvl = 1'b0;
    drain();

    // R6: timeout with no ready fall
    timeoutLimit = 16'd40;
    arm('0);
    expectItem("R6 timeout", 0, 64'd0, 32'd0, 1'b1, 1'b0);
    issue(2'd0, 1'b0, 3'd3, 32'd0);
    drain();
    chk("R6 cs released", 64'(spiCsN), 64'd1);
    timeoutLimit = 16'd400;

    // R7: set append flag via mode register, then 32-bit data read
    arm('0);
    expectItem("R7 write mode", 32, 64'({8'h08, 24'h100060}), 32'd0, 1'b0, 1'b0);
    issue(2'd0, 1'b1, 3'd1, 32'h00100060);
    drain();
    arm({8'h00, 32'h12345687, 24'h0});
    expectItem("R7 data read 32", 40, 64'({8'h58, 32'h0}), 32'h12345687, 1'b0, 1'b0);
    issue(2'd0, 1'b0, 3'd3, 32'd0);
    repeat (10) @(negedge clk);
    readyLvl = 1'b0;
    drain();

    // R8: reset burst and holdoff
    arm('0);
    expectItem("R8 reset burst", 48, 64'hFFFF_FFFF_FFFF, 32'd0, 1'b0, 1'b0);
    issue(2'd1, 1'b0, 3'd0, 32'd0);
    while (spiCsN !== 1'b1) @(negedge clk);
    cnt = 0; readyBad = 1'b0;
    while (!reqAck) begin
      if (reqReady) readyBad = 1'b1;
      @(negedge clk);
      cnt++;
    end
    chk("R8 holdoff cycles", 64'(cnt), 64'(Hold));
    chk("R8 ready low in holdoff", 64'(readyBad), 64'd0);
    drain();

    // R8: append flag cleared -> 24-bit data read
    arm({8'h00, 24'h5A5A5A, 32'h0});
    expectItem("R8 append cleared", 32, 64'({8'h58, 24'h0}), 32'h005A5A5A, 1'b0, 1'b0);
    issue(2'd0, 1'b0, 3'd3, 32'd0);
    repeat (10) @(negedge clk);
    readyLvl = 1'b0;
    drain();

    // R12: leave outside streaming
    arm('0);
    expectItem("R12 stray leave", 0, 64'd0, 32'd0, 1'b0, 1'b0);
    issue(2'd3, 1'b0, 3'd0, 32'd0);
    drain();

    // R9: enter streaming, two 24-bit results
    arm('0);
    expectItem("R9 enter stream", 8, 64'h5C, 32'd0, 1'b0, 1'b0);
    issue(2'd2, 1'b0, 3'd0, 32'd0);
    drain();
    expectItem("R9 stream 1", 24, 64'd0, 32'h00ABC123, 1'b0, 1'b1);
    arm({24'hABC123, 40'h0});
    repeat (6) @(negedge clk);
    readyLvl = 1'b0;
    drain();
    chk("R9 cs held", 64'(spiCsN), 64'd0);
    expectItem("R9 stream 2", 24, 64'd0, 32'h000F0F0E, 1'b0, 1'b1);
    arm({24'h0F0F0E, 40'h0});
    repeat (6) @(negedge clk);
    readyLvl = 1'b0;
    drain();

    // R11: other request while streaming
    arm('0);
    expectItem("R11 reject in stream", 0, 64'd0, 32'd0, 1'b1, 1'b0);
    issue(2'd0, 1'b0, 3'd4, 32'd0);
    drain();

    // R10: leave streaming
    expectItem("R10 leave", 0, 64'd0, 32'd0, 1'b0, 1'b0);
    issue(2'd3, 1'b0, 3'd0, 32'd0);
    drain();
    chk("R10 cs released", 64'(spiCsN), 64'd1);
    readyLvl = 1'b0;
    repeat (60) @(negedge clk);   // any stream strobe here is unexpected
    readyLvl = 1'b1;

    // R7 R9: 32-bit streaming with append set
    arm('0);
    expectItem("R7 write mode again", 32, 64'({8'h08, 24'h100000}), 32'd0, 1'b0, 1'b0);
    issue(2'd0, 1'b1, 3'd1, 32'h00100000);
    drain();
    arm('0);
    expectItem("R9 enter stream 32", 8, 64'h5C, 32'd0, 1'b0, 1'b0);
    issue(2'd2, 1'b0, 3'd0, 32'd0);
    drain();
    expectItem("R7 stream 32", 32, 64'd0, 32'h89ABCDEF, 1'b0, 1'b1);
    arm({32'h89ABCDEF, 32'h0});
    repeat (6) @(negedge clk);
    readyLvl = 1'b0;
    drain();
    arm('0);
    expectItem("R10 leave again", 0, 64'd0, 32'd0, 1'b0, 1'b0);
    issue(2'd3, 1'b0, 3'd0, 32'd0);
    drain();
    chk("R13 idle sclk", 64'(spiSclk), 64'd1);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule